// File: doc/BRIEF.md
# Next-PC and Branch Target Unit

This block picks the address of the next instruction for a 32-bit RISC pipeline. Each cycle it takes the current PC, the raw instruction word, a flow-kind code from the decoder, the value of source register A, the saved exception PC and a condition-met bit from the flag evaluator. It chooses between five flows: sequential advance, region jump, PC-relative conditional branch, register-indirect conditional branch and exception return.

The chosen next PC is registered together with a link write request, which carries the return address and the fixed link register index. The register file takes that request and the fetch unit takes the PC. Flag evaluation, fetch and the register file sit outside this block. All outputs appear one clock edge after the inputs that produced them.

Top module: `npc_unit`

## Requirements
- R1: While rst_n is low, next_pc_o is RESET_PC (default 0x0000_0000) and link_we_o is 0. Otherwise every output updates at each rising edge from the inputs present at that edge.
- R2: Flow kind 3'b000, and the unused codes 3'b101 to 3'b111, give next_pc_o = pc_i + 4 with no link.
- R3: Flow kind 3'b001 (jump) gives next_pc_o = {pc_i[31:26], 1'b0, instr_i[24:1], 1'b0}. The upper six PC bits are kept.
- R4: Flow kind 3'b010 (conditional branch) with cond_met_i high gives next_pc_o = pc_i + the 20-bit sign extension of {instr_i[25:16], instr_i[9:1], 1'b0}. Negative offsets move backwards.
- R5: A conditional or register-indirect branch with cond_met_i low gives next_pc_o = pc_i + 4 and link_we_o = 0, whatever its link bit holds.
- R6: Flow kind 3'b011 (register-indirect branch) with cond_met_i high gives next_pc_o = reg_a_i with bit 0 cleared. Its link request is instr_i[15].
- R7: Flow kind 3'b100 (exception return) gives next_pc_o = epc_i with bit 0 cleared. It never links, even with instr_i[0] or instr_i[15] set.
- R8: A jump or a taken conditional branch links when instr_i[0] is 1. Whenever link_we_o is 1, link_data_o is pc_i + 4 of the linking instruction. link_idx_o is always 3.
- R9: All address sums wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kind_i | input | 3 | Flow kind from the decoder |
| instr_i | input | 32 | Instruction word |
| pc_i | input | 32 | Address of the current instruction |
| reg_a_i | input | 32 | Value of source register A |
| epc_i | input | 32 | Saved exception PC |
| cond_met_i | input | 1 | Branch condition is true |
| next_pc_o | output | 32 | Registered next PC |
| link_we_o | output | 1 | Registered link write enable |
| link_idx_o | output | 5 | Link register index (3) |
| link_data_o | output | 32 | Registered return address |

## Verification
The bench targets the jump splice. A jump with bit 25 reachable, or with the region bits dropped, would land in the wrong 64 MiB region. It runs a backward branch whose offset sign bit sits in the upper field, which a design that reverses the two fields or extends from the wrong bit would send forward. It also drives not-taken branches and exception returns that have link bits set, where a design that skips the gate would write register 3. It uses odd register and exception values that catch a missing bit-0 clear, and a PC near the top of the address space to check wrap-around.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int XLEN      = 32;
  localparam int REGION_W  = 6;
  localparam int JDISP_W   = 24;
  localparam int BHI_W     = 10;
  localparam int BLO_W     = 9;
  localparam int BOFF_W    = BHI_W + BLO_W + 1;
  localparam int RIDX_W    = 5;
  localparam int INSN_STEP = 4;

  // instruction field positions
  localparam int JDISP_LSB = 1;
  localparam int BHI_LSB   = 16;
  localparam int BLO_LSB   = 1;
  localparam int LINK_BIT  = 0;
  localparam int UPD_BIT   = 15;

  typedef enum logic [2:0] {
    K_SEQ   = 3'd0,
    K_JUMP  = 3'd1,
    K_BCOND = 3'd2,
    K_BREG  = 3'd3,
    K_RETEX = 3'd4
  } flow_kind_e;

  // one-hot source select positions
  localparam int S_SEQ = 0;
  localparam int S_JMP = 1;
  localparam int S_BCD = 2;
  localparam int S_BRG = 3;
  localparam int S_RTE = 4;
  localparam int NSRC  = 5;

  function automatic logic [XLEN-1:0] seq_addr(input logic [XLEN-1:0] pc);
    return pc + XLEN'(INSN_STEP);
  endfunction

  function automatic logic [XLEN-1:0] clear_lsb(input logic [XLEN-1:0] v);
    return {v[XLEN-1:1], 1'b0};
  endfunction

  function automatic logic [XLEN-1:0] jump_addr(input logic [XLEN-1:0] pc,
                                                input logic [JDISP_W-1:0] disp);
    logic [XLEN-REGION_W-1:0] low;
    low = (XLEN-REGION_W)'({disp, 1'b0});
    return clear_lsb({pc[XLEN-1:XLEN-REGION_W], low});
  endfunction

  function automatic logic [XLEN-1:0] branch_addr(input logic [XLEN-1:0] pc,
                                                  input logic [BHI_W-1:0] hi,
                                                  input logic [BLO_W-1:0] lo);
    logic [BOFF_W-1:0] off;
    off = {hi, lo, 1'b0};
    return clear_lsb(pc + {{(XLEN-BOFF_W){off[BOFF_W-1]}}, off});
  endfunction
endpackage

// File: rtl/npc_target_gen.sv
module npc_target_gen
  import npc_pkg::*;
(
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] instr_i,
  input  logic [XLEN-1:0] reg_a_i,
  input  logic [XLEN-1:0] epc_i,
  output logic [XLEN-1:0] tgt_o [NSRC]
);
  logic [JDISP_W-1:0] jdisp;
  logic [BHI_W-1:0]   bhi;
  logic [BLO_W-1:0]   blo;

  assign jdisp = instr_i[JDISP_LSB +: JDISP_W];
  assign bhi   = instr_i[BHI_LSB +: BHI_W];
  assign blo   = instr_i[BLO_LSB +: BLO_W];

  assign tgt_o[S_SEQ] = seq_addr(pc_i);
  assign tgt_o[S_JMP] = jump_addr(pc_i, jdisp);
  assign tgt_o[S_BCD] = branch_addr(pc_i, bhi, blo);
  assign tgt_o[S_BRG] = clear_lsb(reg_a_i);
  assign tgt_o[S_RTE] = clear_lsb(epc_i);
endmodule

// File: rtl/npc_flow_ctl.sv
module npc_flow_ctl
  import npc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      kind_i,
  input  logic            cond_met_i,
  input  logic [XLEN-1:0] instr_i,
  output logic [NSRC-1:0] sel_oh_o,
  output logic            link_req_o
);
  always_comb begin
    sel_oh_o   = '0;
    link_req_o = 1'b0;
    unique case (kind_i)
      K_JUMP: begin
        sel_oh_o[S_JMP] = 1'b1;
        link_req_o      = instr_i[LINK_BIT];
      end
      K_BCOND: begin
        if (cond_met_i) begin
          sel_oh_o[S_BCD] = 1'b1;
          link_req_o      = instr_i[LINK_BIT];
        end else begin
          sel_oh_o[S_SEQ] = 1'b1;
        end
      end
      K_BREG: begin
        if (cond_met_i) begin
          sel_oh_o[S_BRG] = 1'b1;
          link_req_o      = instr_i[UPD_BIT];
        end else begin
          sel_oh_o[S_SEQ] = 1'b1;
        end
      end
      K_RETEX: sel_oh_o[S_RTE] = 1'b1;
      default: sel_oh_o[S_SEQ] = 1'b1;
    endcase
  end

  // R2
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sel_oh_o) == 1);

  // R7
  retex_nolink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_oh_o[S_RTE] |-> !link_req_o);

  // R5
  nottaken_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((kind_i == K_BCOND || kind_i == K_BREG) && !cond_met_i) |-> (sel_oh_o[S_SEQ] && !link_req_o));
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0000_0000,
  parameter int          LINK_REG = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  kind_i,
  input  logic [31:0] instr_i,
  input  logic [31:0] pc_i,
  input  logic [31:0] reg_a_i,
  input  logic [31:0] epc_i,
  input  logic        cond_met_i,
  output logic [31:0] next_pc_o,
  output logic        link_we_o,
  output logic [4:0]  link_idx_o,
  output logic [31:0] link_data_o
);
  logic [XLEN-1:0] tgt [NSRC];
  logic [NSRC-1:0] sel_oh;
  logic            link_req;
  logic [XLEN-1:0] npc_d;
  logic            past_ok;

  npc_target_gen u_tgt (
    .pc_i    (pc_i),
    .instr_i (instr_i),
    .reg_a_i (reg_a_i),
    .epc_i   (epc_i),
    .tgt_o   (tgt)
  );

  npc_flow_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .kind_i     (kind_i),
    .cond_met_i (cond_met_i),
    .instr_i    (instr_i),
    .sel_oh_o   (sel_oh),
    .link_req_o (link_req)
  );

  always_comb begin
    npc_d = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (sel_oh[i]) npc_d = npc_d | tgt[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      next_pc_o   <= RESET_PC;
      link_we_o   <= 1'b0;
      link_data_o <= '0;
      past_ok     <= 1'b0;
    end else begin
      next_pc_o   <= npc_d;
      link_we_o   <= link_req;
      link_data_o <= seq_addr(pc_i);
      past_ok     <= 1'b1;
    end
  end

  assign link_idx_o = RIDX_W'(LINK_REG);

  // R8
  link_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && link_we_o) |-> (link_data_o == $past(pc_i) + 32'd4));

  // R7
  retex_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(kind_i) == K_RETEX) |-> (next_pc_o == {$past(epc_i[31:1]), 1'b0} && !link_we_o));

  // R3
  jump_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(kind_i) == K_JUMP) |-> (next_pc_o[31:26] == $past(pc_i[31:26])));

  // R6
  breg_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(kind_i) == K_BREG && $past(cond_met_i)) |-> (next_pc_o == {$past(reg_a_i[31:1]), 1'b0}));
endmodule

// File: tb/npc_unit_bench.sv
module npc_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  kind = 3'd0;
  logic [31:0] instr = '0;
  logic [31:0] pc = '0;
  logic [31:0] ra = '0;
  logic [31:0] epc = '0;
  logic        cond = 1'b0;
  logic [31:0] next_pc;
  logic        link_we;
  logic [4:0]  link_idx;
  logic [31:0] link_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  npc_unit u_npc_unit (
    .clk(clk), .rst_n(rst_n), .kind_i(kind), .instr_i(instr), .pc_i(pc),
    .reg_a_i(ra), .epc_i(epc), .cond_met_i(cond), .next_pc_o(next_pc),
    .link_we_o(link_we), .link_idx_o(link_idx), .link_data_o(link_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] k, input logic [31:0] i, input logic [31:0] p,
                      input logic [31:0] a, input logic [31:0] e, input logic c);
    @(negedge clk);
    kind = k; instr = i; pc = p; ra = a; epc = e; cond = c;
    @(negedge clk);
  endtask

  function automatic logic [31:0] mk_branch(input int hi, input int lo, input bit lk);
    return (32'(hi) << 16) | (32'(lo) << 1) | 32'(lk);
  endfunction

  task automatic t_reset();
    check("R1 reset pc", next_pc, 32'h0);
    check("R1 reset link", {31'd0, link_we}, 32'd0);
  endtask

  task automatic t_seq();
    step(3'd0, 32'hFFFF_FFFF, 32'h0000_2000, 0, 0, 1);
    check("R2 seq pc", next_pc, 32'h0000_2004);
    check("R2 seq nolink", {31'd0, link_we}, 0);
    step(3'd6, 32'h1, 32'h0000_3000, 0, 0, 1);
    check("R2 unused kind", next_pc, 32'h0000_3004);
    step(3'd0, 0, 32'hFFFF_FFFC, 0, 0, 0);
    check("R9 wrap", next_pc, 32'h0);
  endtask

  task automatic t_jump();
    // disp all ones, link set, region bits 0x2C
    step(3'd1, 32'h01FF_FFFF, 32'hB3FF_0000, 0, 0, 0);
    check("R3 jump pc", next_pc, 32'hB000_0000 + (32'h00FF_FFFF * 2));
    check("R8 jump link", {31'd0, link_we}, 1);
    check("R8 link data", link_data, 32'hB3FF_0004);
    check("R8 link idx", {27'd0, link_idx}, 3);
    step(3'd1, 32'hFE00_0000 | (32'h0000_1234 << 1), 32'h4000_0010, 0, 0, 1);
    check("R3 jump nolink pc", next_pc, 32'h4000_2468);
    check("R3 jump nolink", {31'd0, link_we}, 0);
  endtask

  task automatic t_bcond();
    step(3'd2, mk_branch(0, 8, 1), 32'h0000_1000, 0, 0, 1);
    check("R4 fwd branch", next_pc, 32'h0000_1010);
    check("R8 branch link", {31'd0, link_we}, 1);
    // offset -4: upper field all ones, lower 0x1FE
    step(3'd2, mk_branch(10'h3FF, 9'h1FE, 0), 32'h0000_1000, 0, 0, 1);
    check("R4 back branch", next_pc, 32'h0000_0FFC);
    // max negative offset -2^19
    step(3'd2, mk_branch(10'h200, 0, 0), 32'h0010_0000, 0, 0, 1);
    check("R4 min offset", next_pc, 32'h0008_0000);
    step(3'd2, mk_branch(0, 8, 1), 32'h0000_1000, 0, 0, 0);
    check("R5 bcond not taken pc", next_pc, 32'h0000_1004);
    check("R5 bcond not taken nolink", {31'd0, link_we}, 0);
  endtask

  task automatic t_breg();
    step(3'd3, 32'h0000_8000, 32'h0000_0100, 32'h1234_5677, 0, 1);
    check("R6 breg target", next_pc, 32'h1234_5676);
    check("R6 breg link", {31'd0, link_we}, 1);
    check("R8 breg link data", link_data, 32'h0000_0104);
    step(3'd3, 32'h0000_0001, 32'h0000_0100, 32'h0000_4000, 0, 1);
    check("R6 breg no update bit", {31'd0, link_we}, 0);
    step(3'd3, 32'h0000_8000, 32'h0000_0200, 32'h0000_4000, 0, 0);
    check("R5 breg not taken pc", next_pc, 32'h0000_0204);
    check("R5 breg not taken nolink", {31'd0, link_we}, 0);
  endtask

  task automatic t_retex();
    step(3'd4, 32'h0000_8001, 32'h0000_0500, 32'h9999_9998, 32'h0000_ABCD, 0);
    check("R7 retex target", next_pc, 32'h0000_ABCC);
    check("R7 retex nolink", {31'd0, link_we}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_seq();
    t_jump();
    t_bcond();
    t_breg();
    t_retex();
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule